// File: doc/BRIEF.md
# Crystal Prescaler with Stop and Test Modes

This block turns a 32.768 kHz crystal clock into the slow count strobe of a long-interval timekeeper. Three cascaded divide stages bring the clock down to an 8.192 kHz point (divide by 4), then to a 1 Hz point (divide by 8192), and finally to one strobe every 32 seconds (divide by 32). Each strobe drives the increment of an external counter and the interrupt pin in the same cycle. A microcontroller can use the interrupt pulse as a wake-up.

A stop input holds the two upper stages cleared while the first stage keeps running. Restarting is therefore exact to within one 8.192 kHz period, which makes it possible to align the count with an external time mark. A fast development mode takes the strobe from the 1 Hz point. A clock-out mode puts the raw crystal clock on the interrupt pin so the oscillator can be measured. All three stage ratios are parameters, so a bench can use small ratios.

Top module: `prescale_chain`

## Requirements
- R1: The first stage counts every clock by PRE_DIV and is never cleared by stop. After reset release its wraps fall on the clock edges numbered k*PRE_DIV, counting edges from 1.
- R2: With fast mode off, `tick_o` is high for exactly one clock cycle after each edge whose number is a multiple of PRE_DIV*MID_DIV*TOP_DIV, counted from reset release while no stop has occurred. It is low in every other cycle.
- R3: With fast mode on, `tick_o` pulses (active high, one cycle) after every wrap of the second stage. Without a stop, these wraps fall on edges that are multiples of PRE_DIV*MID_DIV.
- R4: Changing `fast_i` clears no stage. After fast mode is switched off, the next slow tick falls on the slow grid that was in place before fast mode was entered.
- R5: While `stop_i` is high at a clock edge, the second and third stages are cleared and `tick_o` stays low in the following cycle.
- R6: Let e be the last edge at which `stop_i` was high, and w the first first-stage wrap edge after e. The first tick then follows edge w+(MID_DIV*TOP_DIV-1)*PRE_DIV in slow mode, or edge w+(MID_DIV-1)*PRE_DIV in fast mode.
- R7: While clock-out mode is off, `irq_o` is a one-cycle active-high pulse in exactly the same cycle as each `tick_o` pulse, and is low otherwise.
- R8: `clkout_i` is sampled at each rising edge. From the edge after it is seen high, `irq_o` follows `clk`: high in the high phase and low in the low phase, with no pulses. `tick_o` keeps its normal timing.
- R9: While `rst` is high and after it is released, stop, fast mode and clock-out are off and `tick_o` and `irq_o` are low. The first tick comes a full slow period after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Holds the upper two stages cleared |
| fast_i | input | 1 | Takes the tick from the second-stage wrap |
| clkout_i | input | 1 | Puts the raw clock on the interrupt pin |
| tick_o | output | 1 | One-cycle count strobe |
| irq_o | output | 1 | Interrupt pin level (pulse, or raw clock) |

## Verification
The assertions assume that PRE_DIV is at least 2, so two first-stage wraps can never fall on adjacent edges. They also assume that `stop_i`, `fast_i` and `clkout_i` only change between rising edges and are low during reset. The stimulus meets both assumptions: it changes every control only at falling edges, holds the controls low during reset, and uses ratios of 4, 8 and 4. A stop is released at an edge that is not a first-stage wrap, so the expected restart time depends on the free-running first stage.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned STAGES = 3;

  typedef enum logic {TAP_SLOW = 1'b0, TAP_FAST = 1'b1} tap_e;

  function automatic int unsigned cnt_w(input int unsigned div);
    return (div <= 2) ? 1 : $clog2(div);
  endfunction
endpackage

// File: rtl/pc_stage.sv
module pc_stage #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic wrap_o
);
  localparam int unsigned CW = pc_pkg::cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign wrap_o = adv && !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R1: a wrap returns the stage to zero
  p_wrap_restart_r1: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt == '0));

  // R5: a clear leaves the stage at zero
  p_clear_hold_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/pc_irq_out.sv
module pc_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  input  logic clkout_i,
  output logic irq_o
);
  logic irq_q;
  logic co_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      co_q  <= 1'b0;
    end else begin
      irq_q <= pulse_i;
      co_q  <= clkout_i;
    end
  end

  assign irq_o = co_q ? clk : irq_q;

  // R8: the pin mode follows the enable one edge later
  p_mode_follow_r8: assert property (@(posedge clk) disable iff (rst)
    clkout_i |=> co_q);
endmodule

// File: rtl/prescale_chain.sv
module prescale_chain #(
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned MID_DIV = 8192,
  parameter int unsigned TOP_DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_i,
  input  logic fast_i,
  input  logic clkout_i,
  output logic tick_o,
  output logic irq_o
);
  import pc_pkg::*;

  localparam int unsigned DIVS [STAGES] = '{PRE_DIV, MID_DIV, TOP_DIV};
  localparam int unsigned FAST_TAP = STAGES - 2;
  localparam int unsigned SLOW_TAP = STAGES - 1;

  logic [STAGES-1:0] wrap;
  tap_e tap;
  logic tick_pre;
  logic tick_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_free
      pc_stage #(.DIV(DIVS[g])) u_div (
        .clk(clk), .rst(rst), .clr(1'b0), .adv(1'b1), .wrap_o(wrap[g]));
    end else begin : g_held
      pc_stage #(.DIV(DIVS[g])) u_div (
        .clk(clk), .rst(rst), .clr(stop_i), .adv(wrap[g-1]), .wrap_o(wrap[g]));
    end
  end

  assign tap = fast_i ? TAP_FAST : TAP_SLOW;

  always_comb begin
    tick_pre = (tap == TAP_FAST) ? wrap[FAST_TAP] : wrap[SLOW_TAP];
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_pre;
  end

  assign tick_o = tick_q;

  pc_irq_out u_irq (
    .clk(clk), .rst(rst), .pulse_i(tick_pre), .clkout_i(clkout_i), .irq_o(irq_o));

  // R2: the strobe is one cycle wide
  p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R5: no strobe follows an edge with stop high
  p_stop_silent_r5: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !tick_o);

  // R7: with the pin in pulse mode, the pulse coincides with the strobe
  p_irq_coincident_r7: assert property (@(posedge clk) disable iff (rst)
    (!clkout_i && $stable(clkout_i)) |-> (irq_o == tick_o));
endmodule

// File: tb/tb_prescale_chain.sv
module tb_prescale_chain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_i = 1'b0;
  logic fast_i = 1'b0;
  logic clkout_i = 1'b0;
  logic tick_o, irq_o;

  int errors = 0;
  int checks = 0;
  int edge_n = 0;
  logic co_eff = 1'b0;
  logic done = 1'b0;
  int exp_q[$];
  string tag = "R9";

  always #2 clk = ~clk;

  prescale_chain #(.PRE_DIV(4), .MID_DIV(8), .TOP_DIV(4)) dut (
    .clk(clk), .rst(rst), .stop_i(stop_i), .fast_i(fast_i),
    .clkout_i(clkout_i), .tick_o(tick_o), .irq_o(irq_o));

  always @(posedge clk) begin
    if (!rst) edge_n <= edge_n + 1;
    co_eff <= rst ? 1'b0 : clkout_i;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", req, edge_n, act, exp);
    end
  endtask

  task automatic wait_edge(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  // monitor: low-phase and high-phase comparisons against the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      begin
        logic et;
        et = (exp_q.size() > 0 && exp_q[0] == edge_n);
        if (et) void'(exp_q.pop_front());
        chk({tag, " tick_o"}, tick_o, et);
        chk({(co_eff ? "R8" : "R7"), " irq_o low phase"}, irq_o, co_eff ? 1'b0 : et);
      end
      @(posedge clk);
      #1;
      if (co_eff) chk("R8 irq_o high phase", irq_o, 1'b1);
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R9/R2: slow ticks from reset release, period 128
    exp_q.push_back(128); exp_q.push_back(256); exp_q.push_back(384);
    tag = "R2";
    wait_edge(400);
    // R3: fast ticks on the 32-edge grid
    fast_i = 1'b1; tag = "R3";
    exp_q.push_back(416); exp_q.push_back(448);
    exp_q.push_back(480); exp_q.push_back(512);
    wait_edge(520);
    // R4: slow grid kept after leaving fast mode
    fast_i = 1'b0; tag = "R4";
    exp_q.push_back(640);
    wait_edge(650);
    // R5: stop silences ticks
    stop_i = 1'b1; tag = "R5";
    wait_edge(701);
    // R6/R1: release at 701, first-stage wrap at 704, tick at 704+31*4
    stop_i = 1'b0; tag = "R6";
    exp_q.push_back(828); exp_q.push_back(956); exp_q.push_back(1084);
    wait_edge(1090);
    fast_i = 1'b1; tag = "R5";
    wait_edge(1100);
    stop_i = 1'b1;
    wait_edge(1150);
    // R6 fast: w=1152, tick at 1152+7*4; R4 slow resumes at 1276
    stop_i = 1'b0; tag = "R6";
    exp_q.push_back(1180); exp_q.push_back(1212); exp_q.push_back(1244);
    exp_q.push_back(1276); exp_q.push_back(1404);
    wait_edge(1250);
    fast_i = 1'b0; tag = "R4";
    wait_edge(1410);
    // R8: raw clock on the pin, tick unaffected
    clkout_i = 1'b1; tag = "R8";
    exp_q.push_back(1532);
    wait_edge(1540);
    clkout_i = 1'b0; tag = "R2";
    exp_q.push_back(1660);
    wait_edge(1700);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending ticks: actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule